// File: doc/BRIEF.md
# Dual-Slope / Single-Slope 8-bit PWM Timer

This block is an 8-bit timer that drives one pulse-width modulated output. A prescaler divides the system clock into timer ticks. On each tick the counter steps in one of two patterns. In single-slope (fast) mode it ramps up and wraps around. In dual-slope (phase-correct) mode it ramps up and then back down, so the pulses stay centred in the period.

A compare value sets the duty cycle. It is double-buffered: the value on the input is copied into the active compare register only at the top of the count. A 2-bit output mode field selects one of four behaviours for the pin:
- disconnected,
- toggle,
- non-inverting,
- inverting.

An output enable stands in for the pin direction. The block also brings out the count, a one-clock overflow pulse and a one-clock compare pulse, which are used as event strobes by surrounding logic.

Top module: `pwm_timer`

## Requirements
- R1: After reset, `count` is 0, `pwm_out` is 0, and `ovf_pulse` and `match_pulse` are 0.
- R2: `clk_sel` encoding: 0 stops the timer (`count` holds). Codes 1..7 give one timer tick every N clocks, with N = 1, 8, 32, 64, 128, 256 and 1024 respectively. `count` changes once per tick.
- R3: Fast mode (`slope_mode`=0, with `out_mode` other than 1):
  - `count` steps 0,1,…,255 and then wraps to 0, so the period is 256·N clocks.
  - `ovf_pulse` is high for one clock in the cycle where `count` shows 0 after the wrap.
- R4: Fast mode with `out_mode`=2, where C is the active compare value:
  - `pwm_out` is high for C+1 of every 256 counts.
  - C=0 gives a one-count spike.
  - C=255 gives a constantly high output.
- R5: Fast mode with `out_mode`=3 is the inverse of R4:
  - `pwm_out` is low for C+1 of every 256 counts.
  - C=255 gives a constantly low output.
- R6: Fast mode with `out_mode`=1:
  - The counter wraps at C instead of 255.
  - `pwm_out` toggles at each wrap, giving a 50% duty square wave with a period of 2·(C+1) counts.
  - C=0 toggles on every count.
- R7: Dual-slope mode (`slope_mode`=1):
  - `count` steps 0,1,…,255,254,…,1,0 and repeats, with 255 shown for exactly one count.
  - The period is 510 counts.
  - `ovf_pulse` is high for one clock in the cycle where `count` arrives at 0.
- R8: Dual-slope mode with `out_mode`=2:
  - `pwm_out` is high for 2·C of every 510 counts.
  - The output clears at the compare point on the way up and sets at the compare point on the way down.
  - C=0 gives a constantly low output; C=255 gives a constantly high output.
- R9: Dual-slope mode with `out_mode`=3 is the inverse of R8: `pwm_out` is low for 2·C of every 510 counts.
- R10: `cmp_value` is copied into the active compare register only on the tick that leaves the top of the count. A change made mid-period has no effect until the next period.
- R11: `pwm_out` is 0 in both of these cases:
  - `out_mode`=0, in either mode;
  - `out_mode`=1 in dual-slope mode.
- R12: `pwm_out` is 0 whenever `pin_en` is 0.
- R13: `match_pulse` is high for one clock per compare event:
  - once per period in fast mode;
  - twice per period in dual-slope mode for C in 1..254.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 3 | Prescaler select (0 = stopped) |
| slope_mode | input | 1 | 0 = single-slope, 1 = dual-slope |
| out_mode | input | 2 | 0 off, 1 toggle, 2 non-inverting, 3 inverting |
| cmp_value | input | 8 | Buffered compare value |
| pin_en | input | 1 | Output driver enable |
| pwm_out | output | 1 | Waveform pin |
| count | output | 8 | Current counter value |
| ovf_pulse | output | 1 | One-clock overflow strobe |
| match_pulse | output | 1 | One-clock compare strobe |

## Verification
The bench builds the block with its defaults: an 8-bit counter and a 10-bit prescaler chain. Most tests use prescaler code 1 (divide by one). At that setting a whole single-slope period takes 256 clocks and a whole dual-slope period takes 510 clocks. This short period makes it practical to count the high time over full periods for the interior compare values and for the edge values 0 and 255, in both polarities. Codes 2 and 4 are then used to confirm the divided tick spacing, and code 0 to confirm that the counter stops.

// File: rtl/pwm_timer_pkg.sv
// Package: shared encodings and prescaler tap selection for the PWM timer.
// Assumes all division ratios are powers of two.
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        OUT_OFF       = 2'd0,
        OUT_TOGGLE    = 2'd1,
        OUT_CLR_MATCH = 2'd2,
        OUT_SET_MATCH = 2'd3
    } out_mode_e;

    // Width of the free-running prescaler chain (largest ratio 2**10).
    localparam int PRESC_W = 10;

    // Map a select code to log2 of the division ratio.
    function automatic int presc_shift(input logic [2:0] sel);
        case (sel)
            3'd1:    return 0;
            3'd2:    return 3;
            3'd3:    return 5;
            3'd4:    return 6;
            3'd5:    return 7;
            3'd6:    return 8;
            3'd7:    return 10;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
// Prescaler: a free-running chain that raises tick once every 2**k clocks,
// where k is chosen by sel. Select code 0 stops the chain and the ticks.
// Assumes sel is held stable while a measurement relies on tick spacing.
module pwm_prescaler
    import pwm_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       tick
);

    logic [PRESC_W-1:0] chain;
    logic [PRESC_W-1:0] mask;

    // Build the low-bit mask for the chosen ratio.
    always_comb begin
        mask = PRESC_W'((1 << presc_shift(sel)) - 1);
        tick = (sel != 3'd0) && ((chain & mask) == mask);
    end

    // Advance the chain while running, clear it when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || sel == 3'd0) chain <= '0;
        else                       chain <= chain + 1'b1;
    end

endmodule

// File: rtl/pwm_counter.sv
// Counter: single-slope ramp wrapping after top, or dual-slope ramp
// turning at the maximum and at zero. It exposes the next value, the
// step direction and the top flag, so that the waveform logic can act
// on the same tick. Assumes top equals the maximum in dual-slope mode.
module pwm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             phase,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] nxt_count,
    output logic             step_up,
    output logic             at_top
);

    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    logic up, up_nxt;

    // Work out the next count and direction for the coming tick.
    always_comb begin
        nxt_count = count;
        step_up   = 1'b1;
        up_nxt    = up;
        at_top    = 1'b0;
        if (phase) begin
            if (up) begin
                if (count == MAXV) begin
                    nxt_count = count - 1'b1;
                    up_nxt    = 1'b0;
                    step_up   = 1'b0;
                    at_top    = 1'b1;
                end else begin
                    nxt_count = count + 1'b1;
                end
            end else if (count == '0) begin
                nxt_count = count + 1'b1;
                up_nxt    = 1'b1;
            end else begin
                nxt_count = count - 1'b1;
                step_up   = 1'b0;
            end
        end else begin
            up_nxt = 1'b1;
            if (count >= top) begin
                nxt_count = '0;
                at_top    = 1'b1;
            end else begin
                nxt_count = count + 1'b1;
            end
        end
    end

    // Commit the count and direction on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            up    <= 1'b1;
        end else if (tick) begin
            count <= nxt_count;
            up    <= up_nxt;
        end
    end

endmodule

// File: rtl/pwm_wavegen.sv
// Waveform generator: holds the active compare register (reloaded from
// the buffered input at the top of the count) and the waveform level,
// applying the set/clear/toggle rules of each slope mode. It also
// produces the overflow and compare strobes. Assumes the counter's flags
// refer to the tick being taken.
module pwm_wavegen
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             phase,
    input  out_mode_e        mode,
    input  logic             pin_en,
    input  logic [CNT_W-1:0] cmp_value,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] nxt_count,
    input  logic             step_up,
    input  logic             at_top,
    output logic [CNT_W-1:0] ocr,
    output logic             pwm_out,
    output logic             ovf_pulse,
    output logic             match_pulse
);

    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    logic [CNT_W-1:0] ocr_nxt;
    logic             wv, wv_nxt, start_lvl, match_hit, ovf_hit, connected;

    // Pick the compare value in force for this tick and detect events.
    always_comb begin
        ocr_nxt   = at_top ? cmp_value : ocr;
        match_hit = phase ? (nxt_count == ocr_nxt) : (count == ocr);
        ovf_hit   = phase ? (nxt_count == '0 && !step_up) : at_top;
        start_lvl = (mode != OUT_SET_MATCH);
    end

    // Apply the set, clear and toggle rules of the active slope mode.
    always_comb begin
        wv_nxt = wv;
        if (!phase) begin
            if (mode == OUT_TOGGLE) begin
                if (match_hit) wv_nxt = ~wv;
            end else if (at_top) begin
                wv_nxt = start_lvl;
            end else if (match_hit) begin
                wv_nxt = ~start_lvl;
            end
        end else begin
            if (ocr_nxt == '0)        wv_nxt = ~start_lvl;
            else if (ocr_nxt == MAXV) wv_nxt = start_lvl;
            else if (match_hit)       wv_nxt = step_up ? ~start_lvl : start_lvl;
        end
    end

    // Register the level, the compare value and the one-clock strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wv          <= 1'b0;
            ocr         <= '0;
            ovf_pulse   <= 1'b0;
            match_pulse <= 1'b0;
        end else if (tick) begin
            wv          <= wv_nxt;
            ocr         <= ocr_nxt;
            ovf_pulse   <= ovf_hit;
            match_pulse <= match_hit;
        end else begin
            ovf_pulse   <= 1'b0;
            match_pulse <= 1'b0;
        end
    end

    // Gate the level onto the pin per output mode and enable.
    always_comb begin
        connected = (mode != OUT_OFF) && !(phase && mode == OUT_TOGGLE);
        pwm_out   = pin_en && connected && wv;
    end

endmodule

// File: rtl/pwm_timer.sv
// Top: prescaler, up/down counter and waveform generator for one PWM pin.
// In single-slope toggle mode the count wraps at the active compare
// value; otherwise it spans the full counter range.
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       clk_sel,
    input  logic             slope_mode,
    input  logic [1:0]       out_mode,
    input  logic [CNT_W-1:0] cmp_value,
    input  logic             pin_en,
    output logic             pwm_out,
    output logic [CNT_W-1:0] count,
    output logic             ovf_pulse,
    output logic             match_pulse
);

    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    out_mode_e        mode;
    logic             tick, step_up, at_top;
    logic [CNT_W-1:0] nxt_count, ocr, top_val;

    // Decode the mode and choose where the single-slope ramp wraps.
    always_comb begin
        mode    = out_mode_e'(out_mode);
        top_val = (!slope_mode && mode == OUT_TOGGLE) ? ocr : MAXV;
    end

    pwm_prescaler u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (clk_sel),
        .tick  (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .phase     (slope_mode),
        .top       (top_val),
        .count     (count),
        .nxt_count (nxt_count),
        .step_up   (step_up),
        .at_top    (at_top)
    );

    pwm_wavegen #(.CNT_W(CNT_W)) u_wave (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .phase       (slope_mode),
        .mode        (mode),
        .pin_en      (pin_en),
        .cmp_value   (cmp_value),
        .count       (count),
        .nxt_count   (nxt_count),
        .step_up     (step_up),
        .at_top      (at_top),
        .ocr         (ocr),
        .pwm_out     (pwm_out),
        .ovf_pulse   (ovf_pulse),
        .match_pulse (match_pulse)
    );

endmodule

// File: rtl/pwm_timer_checker.sv
// Checker: port-level temporal properties of the PWM timer, bound to the top.
module pwm_timer_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       clk_sel,
    input logic             slope_mode,
    input logic [1:0]       out_mode,
    input logic             pin_en,
    input logic             pwm_out,
    input logic [CNT_W-1:0] count,
    input logic             ovf_pulse
);

    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    // R3 and R7: the overflow strobe only accompanies a zero count.
    a_r3_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (count == '0));

    // R2: a stopped prescaler freezes the count.
    a_r2_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd0) |=> $stable(count));

    // R12: a disabled driver keeps the pin low.
    a_r12_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_en |-> !pwm_out);

    // R11: the disconnected mode keeps the pin low.
    a_r11_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == 2'd0) |-> !pwm_out);

    // R7: in dual-slope mode the maximum is left only by stepping down.
    a_r7_turn_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        (slope_mode && count == MAXV) |=>
            (!slope_mode || count == MAXV || count == MAXV - 1'b1));

    // R3: in single-slope full-range mode the maximum is followed by zero.
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!slope_mode && out_mode != 2'd1 && count == MAXV) |=>
            (slope_mode || count == '0 || count == MAXV));

endmodule

bind pwm_timer pwm_timer_checker #(.CNT_W(CNT_W)) u_pwm_timer_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_sel    (clk_sel),
    .slope_mode (slope_mode),
    .out_mode   (out_mode),
    .pin_en     (pin_en),
    .pwm_out    (pwm_out),
    .count      (count),
    .ovf_pulse  (ovf_pulse)
);

// File: tb/pwm_timer_bench.sv
// Directed bench for pwm_timer: one task per scenario, each checking itself.
module pwm_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_sel = 3'd0;
    logic       slope_mode = 1'b0;
    logic [1:0] out_mode = 2'd0;
    logic [7:0] cmp_value = 8'd0;
    logic       pin_en = 1'b0;
    logic       pwm_out;
    logic [7:0] count;
    logic       ovf_pulse;
    logic       match_pulse;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    pwm_timer u_pwm_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_sel     (clk_sel),
        .slope_mode  (slope_mode),
        .out_mode    (out_mode),
        .cmp_value   (cmp_value),
        .pin_en      (pin_en),
        .pwm_out     (pwm_out),
        .count       (count),
        .ovf_pulse   (ovf_pulse),
        .match_pulse (match_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ovf(input int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!ovf_pulse);
        end
    endtask

    task automatic high_count(input int len, output int hi);
        hi = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            hi += int'(pwm_out);
        end
    endtask

    task automatic setup(input logic ph, input logic [1:0] om, input logic [7:0] c);
        @(negedge clk);
        clk_sel    = 3'd1;
        slope_mode = ph;
        out_mode   = om;
        cmp_value  = c;
        pin_en     = 1'b1;
        wait_ovf(2);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 count", int'(count), 0);
        chk("R1 pwm_out", int'(pwm_out), 0);
        chk("R1 ovf_pulse", int'(ovf_pulse), 0);
        chk("R1 match_pulse", int'(match_pulse), 0);
    endtask

    task automatic t_fast_noninv();
        int hi;
        int vals[3] = '{0, 100, 255};
        foreach (vals[i]) begin
            setup(1'b0, 2'd2, 8'(vals[i]));
            high_count(256, hi);
            chk($sformatf("R4 fast noninv C=%0d", vals[i]), hi, vals[i] + 1);
        end
    endtask

    task automatic t_fast_inv();
        int hi;
        int vals[3] = '{0, 100, 255};
        foreach (vals[i]) begin
            setup(1'b0, 2'd3, 8'(vals[i]));
            high_count(256, hi);
            chk($sformatf("R5 fast inv C=%0d", vals[i]), hi, 255 - vals[i]);
        end
    endtask

    task automatic t_fast_toggle();
        int hi;
        int flips;
        logic prev;
        setup(1'b0, 2'd1, 8'd3);
        high_count(256, hi);
        chk("R6 toggle C=3 duty", hi, 128);
        setup(1'b0, 2'd1, 8'd0);
        @(negedge clk);
        prev  = pwm_out;
        flips = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (pwm_out != prev) flips++;
            prev = pwm_out;
        end
        chk("R6 toggle C=0 flips every clock", flips, 16);
    endtask

    task automatic t_phase_noninv();
        int hi;
        int vals[4] = '{0, 1, 100, 255};
        foreach (vals[i]) begin
            setup(1'b1, 2'd2, 8'(vals[i]));
            high_count(510, hi);
            chk($sformatf("R8 phase noninv C=%0d", vals[i]), hi, 2 * vals[i]);
        end
    endtask

    task automatic t_phase_inv();
        int hi;
        int vals[3] = '{0, 100, 255};
        foreach (vals[i]) begin
            setup(1'b1, 2'd3, 8'(vals[i]));
            high_count(510, hi);
            chk($sformatf("R9 phase inv C=%0d", vals[i]), hi, 510 - 2 * vals[i]);
        end
    endtask

    task automatic t_disconnect();
        int hi;
        setup(1'b0, 2'd0, 8'd200);
        high_count(256, hi);
        chk("R11 fast off mode pin", hi, 0);
        setup(1'b1, 2'd1, 8'd100);
        high_count(510, hi);
        chk("R11 phase toggle code pin", hi, 0);
    endtask

    task automatic t_pin_off();
        int hi;
        setup(1'b0, 2'd2, 8'd255);
        pin_en = 1'b0;
        high_count(256, hi);
        chk("R12 pin disabled", hi, 0);
        pin_en = 1'b1;
        high_count(256, hi);
        chk("R12 pin re-enabled", hi, 256);
    endtask

    task automatic t_buffer();
        int hi;
        setup(1'b0, 2'd2, 8'd100);
        wait_ovf(1);
        cmp_value = 8'd200;
        hi = int'(pwm_out);
        for (int i = 0; i < 255; i++) begin
            @(negedge clk);
            hi += int'(pwm_out);
        end
        chk("R10 current period keeps old value", hi, 101);
        high_count(256, hi);
        chk("R10 next period takes new value", hi, 201);
    endtask

    task automatic t_fast_count();
        setup(1'b0, 2'd2, 8'd50);
        wait_ovf(1);
        chk("R3 count at wrap", int'(count), 0);
        repeat (255) @(negedge clk);
        chk("R3 count at max", int'(count), 255);
        chk("R3 no ovf at max", int'(ovf_pulse), 0);
        @(negedge clk);
        chk("R3 wrap count", int'(count), 0);
        chk("R3 ovf on wrap", int'(ovf_pulse), 1);
    endtask

    task automatic t_phase_count();
        setup(1'b1, 2'd2, 8'd50);
        wait_ovf(1);
        repeat (255) @(negedge clk);
        chk("R7 count at top", int'(count), 255);
        @(negedge clk);
        chk("R7 top held one count", int'(count), 254);
        repeat (254) @(negedge clk);
        chk("R7 back at zero", int'(count), 0);
        chk("R7 ovf at zero", int'(ovf_pulse), 1);
    endtask

    task automatic t_match();
        int m;
        setup(1'b0, 2'd2, 8'd100);
        m = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            m += int'(match_pulse);
        end
        chk("R13 fast match per period", m, 1);
        setup(1'b1, 2'd2, 8'd100);
        m = 0;
        for (int i = 0; i < 510; i++) begin
            @(negedge clk);
            m += int'(match_pulse);
        end
        chk("R13 phase matches per period", m, 2);
    endtask

    task automatic measure_tick(input logic [2:0] sel, input int n);
        logic [7:0] prev;
        int gap;
        setup(1'b0, 2'd2, 8'd10);
        clk_sel = sel;
        prev = count;
        do @(negedge clk); while (count == prev);
        prev = count;
        gap  = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (count == prev);
        chk($sformatf("R2 tick spacing sel=%0d", sel), gap, n);
    endtask

    task automatic t_prescaler();
        logic [7:0] held;
        int moved;
        measure_tick(3'd2, 8);
        measure_tick(3'd4, 64);
        clk_sel = 3'd0;
        @(negedge clk);
        held  = count;
        moved = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (count != held) moved++;
        end
        chk("R2 stopped count holds", moved, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fast_count();
        t_fast_noninv();
        t_fast_inv();
        t_fast_toggle();
        t_phase_count();
        t_phase_noninv();
        t_phase_inv();
        t_disconnect();
        t_pin_off();
        t_buffer();
        t_match();
        t_prescaler();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule